// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, together with the current pixel column and row. It does not fetch pixels. A pixel pipeline alongside it uses the data-enable strobe and the position outputs to place its data. Each timing figure is given as a cumulative boundary measured from the start of the line or frame, not as a separate width. The sync phase ends at the first boundary, the back porch at the second, active video at the third, and the counter wraps at the fourth.

Software programs the block over a simple word-addressed register bus. Writes to the timing and line-position registers land in a shadow set. The counters only see a value once it has been copied into the active set. Software asks for that copy either at once or at the next frame wrap. A control register holds the global enable and one polarity select for each output strobe. An interrupt unit collects four events: a programmed line being reached, a fetch-underrun strobe, a transfer-error strobe, and a completed reload. Each event can be masked and cleared. Software can read the position and the unpolarized strobe states back at any time.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset every register reads zero, the counters are zero, irq is low and lcd_pclk_pol is low. Because polarity 0 means active low, lcd_hsync, lcd_vsync and lcd_de are then high (inactive).
- R2: With the enable set, X advances by one per clock from 0 up to the active horizontal total, then wraps to 0. Y advances by one on each X wrap, from 0 up to the active vertical total, then wraps to 0. Both are visible on pos_x and pos_y.
- R3: The logical hsync is true while X <= horizontal sync boundary. The logical horizontal enable is true while back-porch boundary < X <= active boundary. The vertical strobes follow the same rules on Y. lcd_de is the AND of both enables.
- R4: Control register bits 31, 30, 29 and 28 select the polarity of hsync, vsync, DE and the pixel clock. A value of 1 drives the logical value to the pin and a value of 0 inverts it. Bit 28 is driven straight to lcd_pclk_pol.
- R5: When control bit 0 (enable) is 0, all three strobes are inactive at once, and from the next clock the counters are held at zero.
- R6: Writes to the timing registers (word addresses 0 to 3) and the line register (9) read back at once, but the counters do not use them until a reload. Timing registers carry the horizontal field in bits [27:16] and the vertical field in bits [10:0], in this order: 0 sync, 1 back porch, 2 active, 3 total.
- R7: Writing 1 to bit 0 of the reload register (address 5) copies shadow to active at the next clock edge. The bit reads 1 until that edge and 0 after it.
- R8: Writing 1 to bit 1 of the reload register requests a copy on the first cycle after the counters wrap to (0,0). The copy lands at the end of that cycle. The bit reads 1 until then.
- R9: The status register (7) holds bit 0 line, bit 1 underrun (input underrun_strobe), bit 2 transfer error (input xfer_err_strobe) and bit 3 reload done. Each flag is set at the clock edge that ends the cycle in which its event is seen.
- R10: The line event is seen in the cycle where the enable is set, X is 0 and Y equals the line register's active value (bits [10:0]).
- R11: Writing 1 to a bit of the clear register (8) clears that status flag, and 0 bits have no effect. An event in the same cycle wins over the clear.
- R12: irq is high whenever any status flag is set whose bit in the enable register (6, same bit layout) is also set.
- R13: The position register (10) returns X in bits [31:16] and Y in bits [15:0]. The strobe-state register (11) returns the logical vertical enable in bit 0, horizontal enable in bit 1, vsync in bit 2 and hsync in bit 3, before polarity. Control is at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| underrun_strobe | input | 1 | One-cycle pulse that sets the underrun flag |
| xfer_err_strobe | input | 1 | One-cycle pulse that sets the transfer-error flag |
| lcd_hsync | output | 1 | Horizontal sync pin, after polarity |
| lcd_vsync | output | 1 | Vertical sync pin, after polarity |
| lcd_de | output | 1 | Data-enable pin, after polarity |
| lcd_pclk_pol | output | 1 | Selected pixel-clock edge polarity |
| pos_x | output | 12 | Current column counter |
| pos_y | output | 11 | Current row counter |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach is the frame-boundary reload. The request must stay pending for almost a whole frame while the shadow set already holds a different line length, and the copy must land exactly one cycle after the counters reach (0,0). The stimulus starts the counters from a known point by toggling the enable. It then writes a longer horizontal total and the frame-wrap request, and reads the position just before the wrap, just after the copy, and a full new line later. Each reading separates the old line length from the new one. Same-cycle races are forced the same way: an event strobe is driven in the very cycle a clear is written, and a reload copy is taken while the counters are stopped.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int HBITS      = 12;
  localparam int VBITS      = 11;
  localparam int AW         = 4;
  localparam int DW         = 32;
  localparam int NIRQ       = 4;
  localparam int HFIELD_LSB = 16;
  localparam int POSW       = DW / 2;

  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_PCPOL = 28;
  localparam int CB_DEPOL = 29;
  localparam int CB_VSPOL = 30;
  localparam int CB_HSPOL = 31;

  // interrupt bit positions
  localparam int IB_LINE = 0;
  localparam int IB_UNDR = 1;
  localparam int IB_XERR = 2;
  localparam int IB_RELD = 3;

  typedef enum logic [AW-1:0] {
    RA_SYNC   = 4'd0,
    RA_BPORCH = 4'd1,
    RA_ACTIVE = 4'd2,
    RA_TOTAL  = 4'd3,
    RA_CTRL   = 4'd4,
    RA_RELOAD = 4'd5,
    RA_IEN    = 4'd6,
    RA_ISTAT  = 4'd7,
    RA_ICLR   = 4'd8,
    RA_LINE   = 4'd9,
    RA_POS    = 4'd10,
    RA_STAT   = 4'd11
  } lcdt_addr_e;

  typedef struct packed {
    logic [HBITS-1:0] h_sync;
    logic [HBITS-1:0] h_bp;
    logic [HBITS-1:0] h_act;
    logic [HBITS-1:0] h_tot;
    logic [VBITS-1:0] v_sync;
    logic [VBITS-1:0] v_bp;
    logic [VBITS-1:0] v_act;
    logic [VBITS-1:0] v_tot;
    logic [VBITS-1:0] line;
  } lcdt_timing_t;
endpackage

// File: rtl/lcdt_shadow_regs.sv
module lcdt_shadow_regs
  import lcdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          vwrap_evt,
  output lcdt_timing_t  shadow,
  output lcdt_timing_t  active,
  output logic          imm_pend,
  output logic          vb_pend,
  output logic          reload_done
);
  logic set_imm, set_vb, do_copy;
  logic [HBITS-1:0] wh;
  logic [VBITS-1:0] wv;
  logic unused_wdata;

  assign wh        = wdata[HFIELD_LSB +: HBITS];
  assign wv        = wdata[VBITS-1:0];
  assign set_imm   = we && (addr == RA_RELOAD) && wdata[0];
  assign set_vb    = we && (addr == RA_RELOAD) && wdata[1];
  assign do_copy   = imm_pend || (vb_pend && vwrap_evt);
  assign reload_done = do_copy;
  assign unused_wdata = ^{wdata[DW-1:HFIELD_LSB+HBITS], wdata[HFIELD_LSB-1:VBITS]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (we) begin
      case (addr)
        RA_SYNC:   begin shadow.h_sync <= wh; shadow.v_sync <= wv; end
        RA_BPORCH: begin shadow.h_bp   <= wh; shadow.v_bp   <= wv; end
        RA_ACTIVE: begin shadow.h_act  <= wh; shadow.v_act  <= wv; end
        RA_TOTAL:  begin shadow.h_tot  <= wh; shadow.v_tot  <= wv; end
        RA_LINE:   shadow.line <= wv;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= '0;
      imm_pend <= 1'b0;
      vb_pend  <= 1'b0;
    end else begin
      if (do_copy) active <= shadow;
      imm_pend <= set_imm;
      vb_pend  <= (vb_pend && !vwrap_evt) || set_vb;
    end
  end

  AST_IMM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_pend && !set_imm) |=> !imm_pend); // R7
  AST_VB_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_pend && !vwrap_evt) |=> vb_pend); // R8
endmodule

// File: rtl/lcdt_counters.sv
module lcdt_counters
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  lcdt_timing_t     tim,
  output logic [HBITS-1:0] hcnt,
  output logic [VBITS-1:0] vcnt,
  output logic             hs_l,
  output logic             vs_l,
  output logic             hde_l,
  output logic             vde_l,
  output logic             frame_wrap,
  output logic             line_hit
);
  logic hwrap, vwrap;

  assign hwrap = hcnt >= tim.h_tot;
  assign vwrap = vcnt >= tim.v_tot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt       <= '0;
      vcnt       <= '0;
      frame_wrap <= 1'b0;
    end else if (!en) begin
      hcnt       <= '0;
      vcnt       <= '0;
      frame_wrap <= 1'b0;
    end else begin
      hcnt       <= hwrap ? '0 : hcnt + HBITS'(1);
      if (hwrap) vcnt <= vwrap ? '0 : vcnt + VBITS'(1);
      frame_wrap <= hwrap && vwrap;
    end
  end

  assign hs_l     = en && (hcnt <= tim.h_sync);
  assign vs_l     = en && (vcnt <= tim.v_sync);
  assign hde_l    = en && (hcnt > tim.h_bp) && (hcnt <= tim.h_act);
  assign vde_l    = en && (vcnt > tim.v_bp) && (vcnt <= tim.v_act);
  assign line_hit = en && (hcnt == '0) && (vcnt == tim.line);

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hcnt == '0 && vcnt == '0)); // R5
  AST_HWRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hcnt >= tim.h_tot) |=> (hcnt == '0)); // R2
  AST_VHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hcnt < tim.h_tot) |=> (vcnt == $past(vcnt))); // R2
endmodule

// File: rtl/lcdt_irq_ctl.sv
module lcdt_irq_ctl
  import lcdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] set_vec,
  input  logic            clr_we,
  input  logic [NIRQ-1:0] clr_bits,
  input  logic            ien_we,
  input  logic [NIRQ-1:0] ien_bits,
  output logic [NIRQ-1:0] status,
  output logic [NIRQ-1:0] ien,
  output logic            irq
);
  logic [NIRQ-1:0] clr_vec;
  assign clr_vec = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      ien    <= '0;
    end else begin
      status <= (status & ~clr_vec) | set_vec;
      if (ien_we) ien <= ien_bits;
    end
  end

  assign irq = |(status & ien);

  AST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec))); // R9
  AST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((status & $past(clr_vec & ~set_vec)) == '0)); // R11
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             underrun_strobe,
  input  logic             xfer_err_strobe,
  output logic             lcd_hsync,
  output logic             lcd_vsync,
  output logic             lcd_de,
  output logic             lcd_pclk_pol,
  output logic [HBITS-1:0] pos_x,
  output logic [VBITS-1:0] pos_y,
  output logic             irq
);
  lcdt_timing_t shadow, active;
  logic imm_pend, vb_pend, reload_done, frame_wrap, line_hit;
  logic hs_l, vs_l, hde_l, vde_l;
  logic [HBITS-1:0] hcnt;
  logic [VBITS-1:0] vcnt;
  logic [NIRQ-1:0]  status, ien, set_vec;
  logic en, pol_h, pol_v, pol_de, pol_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, pol_h, pol_v, pol_de, pol_pc} <= '0;
    end else if (reg_we && reg_addr == RA_CTRL) begin
      en     <= reg_wdata[CB_EN];
      pol_h  <= reg_wdata[CB_HSPOL];
      pol_v  <= reg_wdata[CB_VSPOL];
      pol_de <= reg_wdata[CB_DEPOL];
      pol_pc <= reg_wdata[CB_PCPOL];
    end
  end

  lcdt_shadow_regs u_regs (
    .clk, .rst_n, .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .vwrap_evt(frame_wrap), .shadow, .active, .imm_pend, .vb_pend, .reload_done
  );

  lcdt_counters u_cnt (
    .clk, .rst_n, .en, .tim(active), .hcnt, .vcnt,
    .hs_l, .vs_l, .hde_l, .vde_l, .frame_wrap, .line_hit
  );

  always_comb begin
    set_vec          = '0;
    set_vec[IB_LINE] = line_hit;
    set_vec[IB_UNDR] = underrun_strobe;
    set_vec[IB_XERR] = xfer_err_strobe;
    set_vec[IB_RELD] = reload_done;
  end

  lcdt_irq_ctl u_irq (
    .clk, .rst_n, .set_vec,
    .clr_we(reg_we && reg_addr == RA_ICLR), .clr_bits(reg_wdata[NIRQ-1:0]),
    .ien_we(reg_we && reg_addr == RA_IEN), .ien_bits(reg_wdata[NIRQ-1:0]),
    .status, .ien, .irq
  );

  assign lcd_hsync    = ~(hs_l ^ pol_h);
  assign lcd_vsync    = ~(vs_l ^ pol_v);
  assign lcd_de       = ~((hde_l && vde_l) ^ pol_de);
  assign lcd_pclk_pol = pol_pc;
  assign pos_x        = hcnt;
  assign pos_y        = vcnt;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_SYNC:   begin reg_rdata[HFIELD_LSB +: HBITS] = shadow.h_sync; reg_rdata[VBITS-1:0] = shadow.v_sync; end
      RA_BPORCH: begin reg_rdata[HFIELD_LSB +: HBITS] = shadow.h_bp;   reg_rdata[VBITS-1:0] = shadow.v_bp;   end
      RA_ACTIVE: begin reg_rdata[HFIELD_LSB +: HBITS] = shadow.h_act;  reg_rdata[VBITS-1:0] = shadow.v_act;  end
      RA_TOTAL:  begin reg_rdata[HFIELD_LSB +: HBITS] = shadow.h_tot;  reg_rdata[VBITS-1:0] = shadow.v_tot;  end
      RA_CTRL: begin
        reg_rdata[CB_EN]    = en;
        reg_rdata[CB_HSPOL] = pol_h;
        reg_rdata[CB_VSPOL] = pol_v;
        reg_rdata[CB_DEPOL] = pol_de;
        reg_rdata[CB_PCPOL] = pol_pc;
      end
      RA_RELOAD: reg_rdata[1:0] = {vb_pend, imm_pend};
      RA_IEN:    reg_rdata[NIRQ-1:0] = ien;
      RA_ISTAT:  reg_rdata[NIRQ-1:0] = status;
      RA_LINE:   reg_rdata[VBITS-1:0] = shadow.line;
      RA_POS: begin
        reg_rdata[DW-1:POSW] = POSW'(hcnt);
        reg_rdata[POSW-1:0]  = POSW'(vcnt);
      end
      RA_STAT:   reg_rdata[3:0] = {hs_l, vs_l, hde_l, vde_l};
      default:   ;
    endcase
  end

  AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (lcd_hsync == !pol_h && lcd_vsync == !pol_v && lcd_de == !pol_de)); // R5
  AST_DE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_de == pol_de) |-> (hcnt > active.h_bp && vcnt > active.v_bp)); // R3
endmodule

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;
  import lcdt_pkg::*;

  localparam int HS = 1, HB = 3, HA = 7, HT = 9;
  localparam int VS = 0, VB = 1, VA = 4, VT = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, reg_we, underrun_strobe, xfer_err_strobe;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic lcd_hsync, lcd_vsync, lcd_de, lcd_pclk_pol, irq;
  logic [HBITS-1:0] pos_x;
  logic [VBITS-1:0] pos_y;

  lcd_timing_gen u_lcd_timing_gen (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .underrun_strobe, .xfer_err_strobe, .lcd_hsync, .lcd_vsync, .lcd_de,
    .lcd_pclk_pol, .pos_x, .pos_y, .irq
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] model(input int h, input int v);
    return {h <= HS, v <= VS, (h > HB) && (h <= HA), (v > VB) && (v <= VA)};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 12; a++) begin
      rd(AW'(a), d);
      check($sformatf("R1 reg %0d", a), d, 0);
    end
    check("R1 pos_x", pos_x, 0);
    check("R1 pos_y", pos_y, 0);
    check("R1 hsync", lcd_hsync, 1);
    check("R1 vsync", lcd_vsync, 1);
    check("R1 de", lcd_de, 1);
    check("R1 pclk_pol", lcd_pclk_pol, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_imm_reload();
    logic [31:0] d;
    wr(RA_SYNC,   (HS << 16) | VS);
    wr(RA_BPORCH, (HB << 16) | VB);
    wr(RA_ACTIVE, (HA << 16) | VA);
    wr(RA_TOTAL,  (HT << 16) | VT);
    rd(RA_TOTAL, d);
    check("R6 shadow readback", d, (HT << 16) | VT);
    wr(RA_RELOAD, 32'h1);
    rd(RA_RELOAD, d);
    check("R7 pending", d, 1);
    idle(1);
    rd(RA_RELOAD, d);
    check("R7 done", d, 0);
    rd(RA_ISTAT, d);
    check("R9 reload flag", d[IB_RELD], 1);
    check("R12 masked", irq, 0);
  endtask

  task automatic t_frame(input bit pol);
    logic [31:0] d;
    logic [3:0] e;
    wr(RA_CTRL, pol ? 32'hF000_0001 : 32'h1);
    for (int k = 0; k < 120; k++) begin
      int h, v;
      h = k % (HT + 1);
      v = (k / (HT + 1)) % (VT + 1);
      e = model(h, v);
      check("R2 x", pos_x, h);
      check("R2 y", pos_y, v);
      check(pol ? "R4 hsync" : "R3 hsync", lcd_hsync, pol ? e[3] : !e[3]);
      check(pol ? "R4 vsync" : "R3 vsync", lcd_vsync, pol ? e[2] : !e[2]);
      check(pol ? "R4 de" : "R3 de", lcd_de, pol ? (e[1] & e[0]) : !(e[1] & e[0]));
      rd(RA_STAT, d);
      check("R13 strobe state", d, e);
      rd(RA_POS, d);
      check("R13 position", d, (h << 16) | v);
      idle(1);
    end
    check("R4 pclk pol", lcd_pclk_pol, pol);
  endtask

  task automatic t_disable();
    wr(RA_CTRL, 32'hF000_0000);
    check("R5 hsync inactive", lcd_hsync, 0);
    check("R5 de inactive", lcd_de, 0);
    idle(2);
    check("R5 x held", pos_x, 0);
    check("R5 y held", pos_y, 0);
  endtask

  task automatic t_vb_reload();
    logic [31:0] d;
    wr(RA_CTRL, 32'h0);
    wr(RA_ICLR, 32'hF);
    wr(RA_CTRL, 32'h1);                  // k=0
    wr(RA_TOTAL, ((HT + 2) << 16) | VT); // k=1
    wr(RA_RELOAD, 32'h2);                // k=2
    rd(RA_RELOAD, d);
    check("R8 pending", d, 2);
    idle(56);                            // k=58
    check("R6 old x", pos_x, 8);
    check("R6 old y", pos_y, 5);
    rd(RA_RELOAD, d);
    check("R8 still pending", d, 2);
    rd(RA_ISTAT, d);
    check("R8 no flag yet", d[IB_RELD], 0);
    idle(4);                             // k=62
    check("R8 x after copy", pos_x, 2);
    check("R8 y after copy", pos_y, 0);
    rd(RA_RELOAD, d);
    check("R8 cleared", d, 0);
    rd(RA_ISTAT, d);
    check("R9 reload flag", d[IB_RELD], 1);
    idle(13);                            // k=75
    check("R8 new line length x", pos_x, 3);
    check("R8 new line length y", pos_y, 1);
  endtask

  task automatic t_line_irq();
    logic [31:0] d;
    wr(RA_CTRL, 32'h0);
    wr(RA_TOTAL, (HT << 16) | VT);
    wr(RA_LINE, 32'd3);
    wr(RA_RELOAD, 32'h1);
    idle(1);
    wr(RA_ICLR, 32'hF);
    wr(RA_IEN, 32'h1);
    wr(RA_CTRL, 32'h1);                  // k=0
    idle(30);
    rd(RA_ISTAT, d);
    check("R10 before line", d[IB_LINE], 0);
    check("R12 irq low", irq, 0);
    idle(1);
    rd(RA_ISTAT, d);
    check("R10 line flag", d[IB_LINE], 1);
    check("R12 irq high", irq, 1);
    wr(RA_ICLR, 32'h2);
    rd(RA_ISTAT, d);
    check("R11 zero bit no effect", d[IB_LINE], 1);
    wr(RA_ICLR, 32'h1);
    rd(RA_ISTAT, d);
    check("R11 line cleared", d[IB_LINE], 0);
    check("R12 irq dropped", irq, 0);
  endtask

  task automatic t_strobes();
    logic [31:0] d;
    wr(RA_CTRL, 32'h0);
    wr(RA_ICLR, 32'hF);
    underrun_strobe = 1'b1;
    idle(1);
    underrun_strobe = 1'b0;
    rd(RA_ISTAT, d);
    check("R9 underrun", d, 32'h2);
    check("R12 masked underrun", irq, 0);
    wr(RA_IEN, 32'h2);
    check("R12 unmasked underrun", irq, 1);
    xfer_err_strobe = 1'b1;
    idle(1);
    xfer_err_strobe = 1'b0;
    rd(RA_ISTAT, d);
    check("R9 transfer error", d, 32'h6);
    underrun_strobe = 1'b1;
    wr(RA_ICLR, 32'h2);
    underrun_strobe = 1'b0;
    rd(RA_ISTAT, d);
    check("R11 set wins", d, 32'h6);
    wr(RA_ICLR, 32'h6);
    rd(RA_ISTAT, d);
    check("R11 both cleared", d, 0);
    check("R12 irq off", irq, 0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    underrun_strobe = 1'b0; xfer_err_strobe = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_imm_reload();
    t_frame(1'b0);
    t_disable();
    t_frame(1'b1);
    t_vb_reload();
    t_line_irq();
    t_strobes();
    done = 1;
    report();
    $finish;
  end
endmodule